// File: doc/BRIEF.md
# Bank-Predicted Memory Port Arbiter

This block is the data-memory front end of a clustered parallel machine. Eight clusters each own a local port. A local port reaches only the two memory banks that belong to its cluster, so the compiler must know the target bank before it issues the access. Because the bank is known in advance, a local access never passes through arbitration. It is started in the cycle it is presented, one per port per cycle, and the accesses are pipelined.

Two global ports carry accesses whose bank is unknown until run time, and they may reach any of the sixteen banks. Each bank accepts one access per cycle. A local access always takes the bank first. The global ports share what is left, in round-robin order between them when both want the same bank. A global read names one of eight holding registers. The register's valid bit drops when the read is issued and rises when the fetched word is written into it. Consumer read ports look up the holding registers. If a consumer names a register whose value has not arrived, the block raises a machine-wide freeze. While the freeze lasts, local requests are held off and global traffic drains.

Top module: `bank_mem_arbiter`

## Requirements
- R1: An address splits into a bank number in bits [3:0] and a word index in bits [7:4]. Cluster c owns banks 2c and 2c+1. A local read to an owned bank, presented in one cycle, raises that cluster's `l_rvalid` in the next cycle, and `l_rdata` then carries the stored word.
- R2: A local port accepts a new access every cycle. Back-to-back local reads return their words in consecutive cycles, in issue order, and each read produces exactly one `l_rvalid` cycle.
- R3: A local request to a bank its cluster does not own raises that cluster's `l_err` in the next cycle. It writes nothing and produces no `l_rvalid`.
- R4: A global port can reach any bank. `g_ready` is high only while that port's `g_valid` is high, and it marks the cycle in which the access is performed. A global write becomes visible to later local reads.
- R5: When a local request and a global request target the same bank in the same cycle, the local request is served and `g_ready` stays low. The global request is served in a later cycle without loss, so a global write issued after a local write leaves the global data in memory.
- R6: When both global ports want the same bank and no local request claims it, exactly one port is granted. Port 0 wins the first such contest after reset, and each later contest goes to the port that lost the previous one.
- R7: Requests to different banks are all served in the same cycle: two global ports plus any local ports.
- R8: A global read granted in cycle T clears its holding register's valid bit from cycle T+1. From cycle T+2 the register holds the fetched word and is valid again.
- R9: `c_data` shows the named holding register at once. `freeze` is high in the same cycle if, and only if, some consumer port with `c_req` set names a register that is not valid.
- R10: While `freeze` is high, local requests have no effect: no write, no `l_err` and no `l_rvalid`. Global requests are still granted and performed, and the freeze ends once the awaited register is filled.
- R11: After reset, every holding register is valid and reads zero, `freeze` is low, and `l_rvalid` and `l_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| l_valid | input | 8 | Local request per cluster |
| l_we | input | 8 | Local write enable per cluster |
| l_addr | input | 8 x 8 | Local address per cluster |
| l_wdata | input | 8 x 16 | Local write data per cluster |
| l_rvalid | output | 8 | Local read data valid, one cycle after issue |
| l_err | output | 8 | Local request aimed at a foreign bank |
| l_rdata | output | 8 x 16 | Local read data per cluster |
| g_valid | input | 2 | Global request per port |
| g_we | input | 2 | Global write enable |
| g_addr | input | 2 x 8 | Global address |
| g_wdata | input | 2 x 16 | Global write data |
| g_tag | input | 2 x 3 | Holding register that receives a global read |
| g_ready | output | 2 | Global request performed this cycle |
| c_req | input | 2 | Consumer wants a holding register |
| c_tag | input | 2 x 3 | Holding register named by a consumer |
| c_data | output | 2 x 16 | Content of the named holding register |
| freeze | output | 1 | Machine-wide stall while awaited data is missing |

## Verification
The stimulus first runs single local accesses, then back-to-back local reads that expose any pipelining slip, then a request to a foreign bank that shows whether the error path also blocks the write. Bank conflicts are tried in three shapes: local against global, global against global, repeated so that the alternation of the round-robin is visible, and traffic spread over disjoint banks, which separates real conflicts from needless serialisation. The freeze case combines a missing holding register with a simultaneous local write, a foreign-bank request and a global write. Reading memory back afterwards tells whether the locals were held off while the global write still went through.

// File: rtl/bma_pkg.sv
package bma_pkg;

    localparam int NCLUST          = 8;
    localparam int BANKS_PER_CLUST = 2;
    localparam int NBANK           = NCLUST * BANKS_PER_CLUST;
    localparam int BANK_W          = $clog2(NBANK);
    localparam int IDX_W           = 4;
    localparam int ADDR_W          = BANK_W + IDX_W;
    localparam int DEPTH           = 1 << IDX_W;
    localparam int DATA_W          = 16;
    localparam int NGLOB           = 2;
    localparam int GSEL_W          = (NGLOB > 1) ? $clog2(NGLOB) : 1;
    localparam int NTAG            = 8;
    localparam int TAG_W           = $clog2(NTAG);
    localparam int NCONS           = 2;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [BANK_W-1:0] bank_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [TAG_W-1:0]  tag_t;

    // One access presented to a bank in a cycle.
    typedef struct packed {
        logic  en;
        logic  we;
        idx_t  idx;
        data_t wdata;
    } bank_op_t;

    // Bank count is a power of two: the bank is the low address bits.
    function automatic bank_t bank_of(addr_t a);
        return a[BANK_W-1:0];
    endfunction

    function automatic idx_t idx_of(addr_t a);
        return a[ADDR_W-1:BANK_W];
    endfunction

    function automatic logic owns(int c, bank_t b);
        return (int'(b) / BANKS_PER_CLUST) == c;
    endfunction

endpackage

// File: rtl/bma_bank.sv
module bma_bank
    import bma_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bank_op_t op,
    output data_t    rdata
);

    // Array with a separate write port and a registered read port.
    data_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (op.en && op.we) begin
            mem[op.idx] <= op.wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (op.en && !op.we) begin
            rdata <= mem[op.idx];
        end
    end

endmodule

// File: rtl/bma_arb.sv
module bma_arb
    import bma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hold_local,
    input  logic [NCLUST-1:0] l_valid,
    input  logic [NCLUST-1:0] l_we,
    input  addr_t             l_addr  [NCLUST],
    input  data_t             l_wdata [NCLUST],
    input  logic [NGLOB-1:0]  g_valid,
    input  logic [NGLOB-1:0]  g_we,
    input  addr_t             g_addr  [NGLOB],
    input  data_t             g_wdata [NGLOB],
    output logic [NCLUST-1:0] l_take,
    output logic [NCLUST-1:0] l_bad,
    output logic [NGLOB-1:0]  g_grant,
    output bank_op_t          op      [NBANK]
);

    logic [GSEL_W-1:0] rr_q;
    logic [GSEL_W-1:0] rr_d;

    // Local side: no arbitration, only an ownership check.
    always_comb begin
        for (int c = 0; c < NCLUST; c++) begin
            l_take[c] = l_valid[c] && !hold_local &&  owns(c, bank_of(l_addr[c]));
            l_bad[c]  = l_valid[c] && !hold_local && !owns(c, bank_of(l_addr[c]));
        end
    end

    // Per-bank selection: owning local first, then global round-robin.
    always_comb begin
        int   oc;
        int   hits;
        int   gi;
        logic found;
        g_grant = '0;
        rr_d    = rr_q;
        oc      = 0;
        hits    = 0;
        gi      = 0;
        found   = 1'b0;
        for (int b = 0; b < NBANK; b++) begin
            op[b] = '0;
            oc    = b / BANKS_PER_CLUST;
            if (l_take[oc] && (bank_of(l_addr[oc]) == BANK_W'(b))) begin
                op[b].en    = 1'b1;
                op[b].we    = l_we[oc];
                op[b].idx   = idx_of(l_addr[oc]);
                op[b].wdata = l_wdata[oc];
            end else begin
                hits  = 0;
                found = 1'b0;
                for (int g = 0; g < NGLOB; g++) begin
                    if (g_valid[g] && (bank_of(g_addr[g]) == BANK_W'(b))) begin
                        hits = hits + 1;
                    end
                end
                for (int k = 0; k < NGLOB; k++) begin
                    gi = (int'(rr_q) + k) % NGLOB;
                    if (!found && g_valid[gi] && (bank_of(g_addr[gi]) == BANK_W'(b))) begin
                        found       = 1'b1;
                        g_grant[gi] = 1'b1;
                        op[b].en    = 1'b1;
                        op[b].we    = g_we[gi];
                        op[b].idx   = idx_of(g_addr[gi]);
                        op[b].wdata = g_wdata[gi];
                        if (hits > 1) begin
                            rr_d = GSEL_W'((gi + 1) % NGLOB);
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_q <= '0;
        end else begin
            rr_q <= rr_d;
        end
    end

endmodule

// File: rtl/bma_hold.sv
module bma_hold
    import bma_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NGLOB-1:0] iss_en,
    input  tag_t             iss_tag   [NGLOB],
    input  logic [NGLOB-1:0] fill_en,
    input  tag_t             fill_tag  [NGLOB],
    input  data_t            fill_data [NGLOB],
    input  logic [NCONS-1:0] c_req,
    input  tag_t             c_tag     [NCONS],
    output data_t            c_data    [NCONS],
    output logic             freeze
);

    data_t            regs [NTAG];
    logic [NTAG-1:0]  ok_q;

    // Fill sets valid; a new issue to the same entry clears it and wins.
    always_ff @(posedge clk) begin
        if (rst) begin
            ok_q <= '1;
            for (int t = 0; t < NTAG; t++) begin
                regs[t] <= '0;
            end
        end else begin
            for (int g = 0; g < NGLOB; g++) begin
                if (fill_en[g]) begin
                    regs[fill_tag[g]] <= fill_data[g];
                    ok_q[fill_tag[g]] <= 1'b1;
                end
            end
            for (int g = 0; g < NGLOB; g++) begin
                if (iss_en[g]) begin
                    ok_q[iss_tag[g]] <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        freeze = 1'b0;
        for (int p = 0; p < NCONS; p++) begin
            c_data[p] = regs[c_tag[p]];
            if (c_req[p] && !ok_q[c_tag[p]]) begin
                freeze = 1'b1;
            end
        end
    end

endmodule

// File: rtl/bank_mem_arbiter.sv
module bank_mem_arbiter
    import bma_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NCLUST-1:0]        l_valid,
    input  logic [NCLUST-1:0]        l_we,
    input  logic [ADDR_W-1:0]        l_addr  [NCLUST],
    input  logic [DATA_W-1:0]        l_wdata [NCLUST],
    output logic [NCLUST-1:0]        l_rvalid,
    output logic [NCLUST-1:0]        l_err,
    output logic [DATA_W-1:0]        l_rdata [NCLUST],
    input  logic [NGLOB-1:0]         g_valid,
    input  logic [NGLOB-1:0]         g_we,
    input  logic [ADDR_W-1:0]        g_addr  [NGLOB],
    input  logic [DATA_W-1:0]        g_wdata [NGLOB],
    input  logic [TAG_W-1:0]         g_tag   [NGLOB],
    output logic [NGLOB-1:0]         g_ready,
    input  logic [NCONS-1:0]         c_req,
    input  logic [TAG_W-1:0]         c_tag   [NCONS],
    output logic [DATA_W-1:0]        c_data  [NCONS],
    output logic                     freeze
);

    logic [NCLUST-1:0] l_take;
    logic [NCLUST-1:0] l_bad;
    logic [NGLOB-1:0]  g_grant;
    bank_op_t          op      [NBANK];
    data_t             bank_rd [NBANK];

    logic [NCLUST-1:0] l_rv_q;
    logic [NCLUST-1:0] l_err_q;
    bank_t             l_bank_q [NCLUST];

    logic [NGLOB-1:0]  g_rd_q;
    tag_t              g_tag_q  [NGLOB];
    bank_t             g_bank_q [NGLOB];
    data_t             fill_data [NGLOB];
    logic [NGLOB-1:0]  iss_en;

    bma_arb u_arb (
        .clk        (clk),
        .rst        (rst),
        .hold_local (freeze),
        .l_valid    (l_valid),
        .l_we       (l_we),
        .l_addr     (l_addr),
        .l_wdata    (l_wdata),
        .g_valid    (g_valid),
        .g_we       (g_we),
        .g_addr     (g_addr),
        .g_wdata    (g_wdata),
        .l_take     (l_take),
        .l_bad      (l_bad),
        .g_grant    (g_grant),
        .op         (op)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        bma_bank u_bank (
            .clk   (clk),
            .rst   (rst),
            .op    (op[b]),
            .rdata (bank_rd[b])
        );
    end

    // Local return path: remember which bank each read used.
    always_ff @(posedge clk) begin
        if (rst) begin
            l_rv_q  <= '0;
            l_err_q <= '0;
            for (int c = 0; c < NCLUST; c++) begin
                l_bank_q[c] <= '0;
            end
        end else begin
            l_rv_q  <= l_take & ~l_we;
            l_err_q <= l_bad;
            for (int c = 0; c < NCLUST; c++) begin
                l_bank_q[c] <= bank_of(l_addr[c]);
            end
        end
    end

    always_comb begin
        for (int c = 0; c < NCLUST; c++) begin
            l_rdata[c] = bank_rd[l_bank_q[c]];
        end
    end

    assign l_rvalid = l_rv_q;
    assign l_err    = l_err_q;

    // Global return path: one stage of tag/bank tracking, then fill.
    assign iss_en  = g_grant & ~g_we;
    assign g_ready = g_grant;

    always_ff @(posedge clk) begin
        if (rst) begin
            g_rd_q <= '0;
            for (int g = 0; g < NGLOB; g++) begin
                g_tag_q[g]  <= '0;
                g_bank_q[g] <= '0;
            end
        end else begin
            g_rd_q <= iss_en;
            for (int g = 0; g < NGLOB; g++) begin
                g_tag_q[g]  <= g_tag[g];
                g_bank_q[g] <= bank_of(g_addr[g]);
            end
        end
    end

    always_comb begin
        for (int g = 0; g < NGLOB; g++) begin
            fill_data[g] = bank_rd[g_bank_q[g]];
        end
    end

    bma_hold u_hold (
        .clk       (clk),
        .rst       (rst),
        .iss_en    (iss_en),
        .iss_tag   (g_tag),
        .fill_en   (g_rd_q),
        .fill_tag  (g_tag_q),
        .fill_data (fill_data),
        .c_req     (c_req),
        .c_tag     (c_tag),
        .c_data    (c_data),
        .freeze    (freeze)
    );

endmodule

// File: rtl/bank_mem_arbiter_chk.sv
module bank_mem_arbiter_chk
    import bma_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [NCLUST-1:0] l_valid,
    input logic [NCLUST-1:0] l_we,
    input logic [ADDR_W-1:0] l_addr [NCLUST],
    input logic [NCLUST-1:0] l_rvalid,
    input logic [NCLUST-1:0] l_err,
    input logic [NGLOB-1:0]  g_valid,
    input logic [ADDR_W-1:0] g_addr [NGLOB],
    input logic [NGLOB-1:0]  g_ready,
    input logic              freeze
);

    AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!freeze && (l_rvalid == '0) && (l_err == '0))); // R11

    for (genvar c = 0; c < NCLUST; c++) begin : g_loc
        AST_LOCAL_READ_RETURNS: assert property (@(posedge clk) disable iff (rst)
            (l_valid[c] && !l_we[c] && !freeze && owns(c, bank_of(l_addr[c])))
            |=> (l_rvalid[c] && !l_err[c])); // R1

        AST_FOREIGN_FLAGGED: assert property (@(posedge clk) disable iff (rst)
            (l_valid[c] && !freeze && !owns(c, bank_of(l_addr[c])))
            |=> (l_err[c] && !l_rvalid[c])); // R3

        AST_FREEZE_HOLDS_LOCAL: assert property (@(posedge clk) disable iff (rst)
            freeze |=> (!l_rvalid[c] && !l_err[c])); // R10
    end

    for (genvar g = 0; g < NGLOB; g++) begin : g_glb
        AST_READY_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
            g_ready[g] |-> g_valid[g]); // R4

        for (genvar c = 0; c < NCLUST; c++) begin : g_vs
            AST_LOCAL_BEATS_GLOBAL: assert property (@(posedge clk) disable iff (rst)
                (g_valid[g] && l_valid[c] && !freeze && owns(c, bank_of(l_addr[c]))
                 && (bank_of(l_addr[c]) == bank_of(g_addr[g]))) |-> !g_ready[g]); // R5
        end

        for (genvar h = g + 1; h < NGLOB; h++) begin : g_pair
            AST_ONE_GLOBAL_PER_BANK: assert property (@(posedge clk) disable iff (rst)
                (g_ready[g] && g_ready[h]) |-> (bank_of(g_addr[g]) != bank_of(g_addr[h]))); // R6
        end
    end

endmodule

bind bank_mem_arbiter bank_mem_arbiter_chk u_chk (.*);

// File: tb/sim_bank_mem_arbiter.sv
module sim_bank_mem_arbiter;
    import bma_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NCLUST-1:0] l_valid, l_we, l_rvalid, l_err;
    logic [ADDR_W-1:0] l_addr  [NCLUST];
    logic [DATA_W-1:0] l_wdata [NCLUST];
    logic [DATA_W-1:0] l_rdata [NCLUST];
    logic [NGLOB-1:0]  g_valid, g_we, g_ready;
    logic [ADDR_W-1:0] g_addr  [NGLOB];
    logic [DATA_W-1:0] g_wdata [NGLOB];
    logic [TAG_W-1:0]  g_tag   [NGLOB];
    logic [NCONS-1:0]  c_req;
    logic [TAG_W-1:0]  c_tag   [NCONS];
    logic [DATA_W-1:0] c_data  [NCONS];
    logic              freeze;

    int  nchk  = 0;
    int  nfail = 0;
    bit  done  = 0;

    always #2 clk = ~clk;

    bank_mem_arbiter u0 (.*);

    function automatic logic [ADDR_W-1:0] ad(int bank, int idx);
        return {IDX_W'(idx), BANK_W'(bank)};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        l_valid = '0; l_we = '0; g_valid = '0; g_we = '0; c_req = '0;
        for (int c = 0; c < NCLUST; c++) begin l_addr[c] = '0; l_wdata[c] = '0; end
        for (int g = 0; g < NGLOB; g++) begin g_addr[g] = '0; g_wdata[g] = '0; g_tag[g] = '0; end
        for (int p = 0; p < NCONS; p++) c_tag[p] = '0;
    endtask

    task automatic lreq(int c, logic we, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
        l_valid[c] = 1'b1; l_we[c] = we; l_addr[c] = a; l_wdata[c] = d;
    endtask

    task automatic greq(int g, logic we, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d, int tag);
        g_valid[g] = 1'b1; g_we[g] = we; g_addr[g] = a; g_wdata[g] = d; g_tag[g] = TAG_W'(tag);
    endtask

    task automatic t_reset();
        check("R11 l_rvalid", 32'(l_rvalid), 0);
        check("R11 l_err", 32'(l_err), 0);
        c_req[0] = 1'b1; c_tag[0] = 3'd3;
        #1;
        check("R11 freeze", 32'(freeze), 0);
        check("R11 c_data zero", 32'(c_data[0]), 0);
        idle();
        @(negedge clk);
    endtask

    task automatic t_local();
        lreq(3, 1, ad(6, 5), 16'hA5A5); @(negedge clk);
        lreq(3, 1, ad(7, 1), 16'h1111); @(negedge clk);
        lreq(3, 1, ad(7, 2), 16'h2222); @(negedge clk);
        lreq(3, 0, ad(6, 5), 0);        @(negedge clk);
        check("R1 rvalid", 32'(l_rvalid[3]), 1);
        check("R1 rdata", 32'(l_rdata[3]), 32'hA5A5);
        lreq(3, 0, ad(7, 1), 0);        @(negedge clk);
        check("R2 rdata first", 32'(l_rdata[3]), 32'h1111);
        lreq(3, 0, ad(7, 2), 0);        @(negedge clk);
        check("R2 rdata second", 32'(l_rdata[3]), 32'h2222);
        idle();                         @(negedge clk);
        check("R2 single rvalid", 32'(l_rvalid[3]), 0);
    endtask

    task automatic t_foreign();
        lreq(0, 1, ad(0, 3), 16'h0BEE); @(negedge clk);
        idle(); lreq(2, 1, ad(0, 3), 16'hDEAD); @(negedge clk);
        check("R3 err on foreign write", 32'(l_err[2]), 1);
        idle(); lreq(0, 0, ad(0, 3), 0); @(negedge clk);
        check("R3 foreign write dropped", 32'(l_rdata[0]), 32'h0BEE);
        check("R3 owner no err", 32'(l_err[0]), 0);
        idle(); lreq(2, 0, ad(9, 0), 0); @(negedge clk);
        check("R3 err on foreign read", 32'(l_err[2]), 1);
        check("R3 no rvalid on foreign read", 32'(l_rvalid[2]), 0);
        idle();
    endtask

    task automatic t_global();
        greq(0, 1, ad(9, 3), 16'h9393, 0);
        #1; check("R4 ready any bank", 32'(g_ready[0]), 1);
        @(negedge clk);
        idle(); lreq(4, 0, ad(9, 3), 0); @(negedge clk);
        check("R4 global write visible", 32'(l_rdata[4]), 32'h9393);
        idle(); greq(1, 0, ad(6, 5), 0, 2);
        #1; check("R4 ready read", 32'(g_ready[1]), 1);
        @(negedge clk);
        idle(); c_req[0] = 1'b1; c_tag[0] = 3'd2; c_req[1] = 1'b0;
        #1; check("R8 valid cleared -> freeze", 32'(freeze), 1);
        @(negedge clk);
        c_req[1] = 1'b1; c_tag[1] = 3'd3;
        #1;
        check("R8 freeze released", 32'(freeze), 0);
        check("R8 fetched word", 32'(c_data[0]), 32'hA5A5);
        check("R9 untouched entry", 32'(c_data[1]), 0);
        idle(); @(negedge clk);
    endtask

    task automatic t_prio();
        lreq(5, 1, ad(10, 2), 16'h5151);
        greq(0, 1, ad(10, 2), 16'h6161, 0);
        #1; check("R5 global waits", 32'(g_ready[0]), 0);
        @(negedge clk);
        l_valid[5] = 1'b0;
        #1; check("R5 global served later", 32'(g_ready[0]), 1);
        @(negedge clk);
        idle(); lreq(5, 0, ad(10, 2), 0); @(negedge clk);
        check("R5 global write kept", 32'(l_rdata[5]), 32'h6161);
        idle();
    endtask

    task automatic t_rr();
        greq(0, 1, ad(12, 0), 16'hC0C0, 0);
        greq(1, 1, ad(12, 1), 16'hC1C1, 0);
        #1; check("R6 first contest port0", 32'(g_ready), 32'b01);
        @(negedge clk);
        g_valid[0] = 1'b0;
        #1; check("R6 loser served", 32'(g_ready), 32'b10);
        @(negedge clk);
        greq(0, 1, ad(12, 2), 16'hC2C2, 0);
        greq(1, 1, ad(12, 3), 16'hC3C3, 0);
        #1; check("R6 second contest port1", 32'(g_ready), 32'b10);
        @(negedge clk);
        g_valid[1] = 1'b0;
        #1; check("R6 port0 after", 32'(g_ready), 32'b01);
        @(negedge clk);
        idle();
        for (int i = 0; i < 4; i++) begin
            lreq(6, 0, ad(12, i), 0);
            @(negedge clk);
            check("R6 contested writes stored", 32'(l_rdata[6]), 32'hC0C0 + 32'(i) * 32'h0101);
        end
        idle();
    endtask

    task automatic t_parallel();
        greq(0, 1, ad(1, 7), 16'h1717, 0);
        greq(1, 1, ad(14, 7), 16'hE7E7, 0);
        lreq(3, 0, ad(6, 5), 0);
        #1; check("R7 both globals granted", 32'(g_ready), 32'b11);
        @(negedge clk);
        check("R7 local alongside", 32'(l_rdata[3]), 32'hA5A5);
        check("R7 local rvalid", 32'(l_rvalid[3]), 1);
        idle(); lreq(0, 0, ad(1, 7), 0); lreq(7, 0, ad(14, 7), 0);
        @(negedge clk);
        check("R7 bank1 data", 32'(l_rdata[0]), 32'h1717);
        check("R7 bank14 data", 32'(l_rdata[7]), 32'hE7E7);
        idle();
    endtask

    task automatic t_freeze();
        greq(0, 0, ad(9, 3), 0, 5);
        #1; check("R10 read issued", 32'(g_ready[0]), 1);
        @(negedge clk);
        idle();
        c_req[0] = 1'b1; c_tag[0] = 3'd5;
        lreq(4, 1, ad(9, 3), 16'h4444);
        lreq(1, 1, ad(0, 0), 16'h0101);
        greq(1, 1, ad(2, 0), 16'h2020, 0);
        #1;
        check("R9 freeze on missing entry", 32'(freeze), 1);
        check("R10 global granted in freeze", 32'(g_ready[1]), 1);
        @(negedge clk);
        check("R10 no err in freeze", 32'(l_err[1]), 0);
        check("R10 no rvalid in freeze", 32'(l_rvalid), 0);
        check("R10 freeze ends", 32'(freeze), 0);
        check("R10 drained data", 32'(c_data[0]), 32'h9393);
        idle(); lreq(4, 0, ad(9, 3), 0); lreq(1, 0, ad(2, 0), 0);
        @(negedge clk);
        check("R10 local write blocked", 32'(l_rdata[4]), 32'h9393);
        check("R10 global write done", 32'(l_rdata[1]), 32'h2020);
        idle();
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    endtask

    initial begin
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_local();
        t_foreign();
        t_global();
        t_prio();
        t_rr();
        t_parallel();
        t_freeze();
        done = 1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog run did not complete");
            finish_run();
        end
    end

endmodule